// File: doc/BRIEF.md
# SGRAM Power-Up and Mode Programming Sequencer

This block sits on the controller side of a synchronous graphics DRAM. It takes the device from power-on to a usable state. After reset it keeps clock enable high and drives no-operation on the command pins for a settle time, which is set in microseconds and counted in clock cycles. It then issues a precharge of every bank. After that it issues a set number of auto-refresh commands and a mode register set, in whichever of the two orders the configuration asks for. When the graphics features are wanted, a special mode set follows the standard one at once, with the DSF pin high, and loads either the color register or the mask register.

The configuration inputs are sampled once, on the last cycle of the settle period, and checked for legality in that same cycle. A legal set of values starts the command sequence. An illegal one stops the sequencer before it issues anything and raises a sticky error. When the last command and its idle spacing are done, a ready flag rises and stays high until the next reset. Read and write traffic, periodic refresh and the data path belong to other blocks.

Top module: `sgramBootSeq`

## Requirements
- R1: While reset is low, and in the first cycle after it, the pins show no-operation. That is csN=0, rasN=1, casN=1, weN=1, with addr=0, dsf=0, cke=1, ready=0 and cfgError=0.
- R2: After reset is released, the pins hold no-operation with cke=1 for exactly CLK_MHZ*SETTLE_US cycles. The first command then appears in the next cycle.
- R3: The first command is precharge-all: csN,rasN,casN,weN = 0,0,1,0 with addr[10]=1, all other address bits 0, and dsf=0.
- R4: Exactly REFRESH_COUNT auto-refresh commands are issued: csN,rasN,casN,weN = 0,0,0,1, addr=0, dsf=0.
- R5: With cfgModeFirst=0 the refreshes come before the mode set. With cfgModeFirst=1 the mode set, and the special mode set if it is enabled, come before the refreshes.
- R6: The mode set drives csN,rasN,casN,weN = 0,0,0,0 with dsf=0. The address carries: burst length code on addr[2:0]; burst type on addr[3] (0 sequential, 1 interleave); CAS latency in binary on addr[6:4]; the single-write-burst enable on addr[9]. Bits addr[10], addr[8] and addr[7] are 0.
- R7: With cfgSpecialEn=1, a special mode set (command 0,0,0,0 with dsf=1) follows the mode set as the next command. Its addr[6] is cfgLoadColor, its addr[5] is cfgLoadMask, and all other address bits are 0.
- R8: Any two consecutive commands are separated by exactly GAP_CYCLES no-operation cycles.
- R9: ready rises GAP_CYCLES+1 cycles after the final command appears on the pins. It then stays high, with no-operation on the pins, until reset.
- R10: The following configurations are illegal: burst length codes 100, 101 and 110; code 111 (full page) with interleave; CAS latency other than 2 or 3; special mode enabled with both load bits set. An illegal configuration raises cfgError at the end of the settle period. No command is ever issued and ready stays low.
- R11: The configuration is taken from the inputs on the last settle cycle. Changes to the inputs before that cycle take effect. Changes after it have no effect on the commands or on cfgError.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgBurstLen | input | 3 | Burst length code: 000=1, 001=2, 010=4, 011=8, 111=full page |
| cfgInterleave | input | 1 | Burst type, 1 = interleave |
| cfgCasLat | input | 3 | CAS latency in cycles (2 or 3) |
| cfgSingleWrite | input | 1 | Enables burst read with single writes |
| cfgModeFirst | input | 1 | 1 = mode set before refreshes |
| cfgSpecialEn | input | 1 | Adds a special mode set after the mode set |
| cfgLoadColor | input | 1 | Special mode set loads the color register |
| cfgLoadMask | input | 1 | Special mode set loads the mask register |
| cke | output | 1 | Clock enable, held high |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| dsf | output | 1 | Selects the special mode set |
| ready | output | 1 | Sequence complete, sticky |
| cfgError | output | 1 | Illegal configuration, sticky |

## Verification
Two things happen in the same cycle, the last cycle of the settle countdown. The configuration is captured, and the legality verdict that decides between starting the sequence and halting is made. The bench checks this boundary from both sides. In one run it starts with an illegal configuration and switches it to a legal one during the settle period; the run must complete with the new mode word and no error. In another run it switches a legal configuration to an illegal one in the cycle the precharge appears; the run must finish with the original word and no error.

// File: rtl/sgramBootPkg.sv
package sgramBootPkg;

  // command pin encoding {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_MRS = 4'b0000
  } cmdT;

  // strobes from control to datapath, at most one command per cycle
  typedef struct packed {
    logic doLatch;
    logic doPre;
    logic doRef;
    logic doMrs;
    logic doSmrs;
  } stbT;

  typedef struct packed {
    logic [2:0] burstLen;
    logic       interleave;
    logic [2:0] casLat;
    logic       singleWrite;
    logic       modeFirst;
    logic       specialEn;
    logic       loadColor;
    logic       loadMask;
  } cfgT;

  // address bit positions decoded by the memory device
  localparam int BIT_ALLBANK   = 10;
  localparam int BIT_SINGLEWR  = 9;
  localparam int BIT_LOADCOLOR = 6;
  localparam int BIT_LOADMASK  = 5;
  localparam int CL_LSB        = 4;
  localparam int BT_BIT        = 3;

endpackage

// File: rtl/sgramBootCtrl.sv
module sgramBootCtrl
  import sgramBootPkg::*;
#(
  parameter int SETTLE_CYC    = 25000,
  parameter int REFRESH_COUNT = 2,
  parameter int GAP_CYCLES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgBad,
  input  logic modeFirst,
  input  logic specialEn,
  output stbT  stb,
  output logic ready,
  output logic cfgError
);

  localparam int SETTLE_W = $clog2(SETTLE_CYC + 1);
  localparam int REF_W    = $clog2(REFRESH_COUNT + 1);
  localparam int GAP_W    = $clog2(GAP_CYCLES + 1);
  localparam int SINCE_W  = $clog2(GAP_CYCLES + 2);

  typedef enum logic [2:0] {
    S_SETTLE, S_PRE, S_REF, S_MRS, S_SMRS, S_GAP, S_DONE, S_FAULT
  } stateT;

  stateT state, follow, followNext;
  logic [SETTLE_W-1:0] settleCnt;
  logic [REF_W-1:0]    refLeft;
  logic [GAP_W-1:0]    gapCnt;
  logic readyQ, errQ;

  // which command comes after the one being issued now
  always_comb begin
    case (state)
      S_PRE:   followNext = modeFirst ? S_MRS : S_REF;
      S_REF:   followNext = (refLeft > REF_W'(1)) ? S_REF
                          : (modeFirst ? S_DONE : S_MRS);
      S_MRS:   followNext = specialEn ? S_SMRS
                          : (modeFirst ? S_REF : S_DONE);
      S_SMRS:  followNext = modeFirst ? S_REF : S_DONE;
      default: followNext = S_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_SETTLE;
      follow    <= S_DONE;
      settleCnt <= SETTLE_W'(SETTLE_CYC - 1);
      refLeft   <= REF_W'(REFRESH_COUNT);
      gapCnt    <= '0;
      readyQ    <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      readyQ <= readyQ | (state == S_DONE);
      errQ   <= errQ | (state == S_FAULT);
      case (state)
        S_SETTLE: begin
          if (settleCnt == '0) state <= cfgBad ? S_FAULT : S_PRE;
          else                 settleCnt <= settleCnt - 1'b1;
        end
        S_PRE, S_REF, S_MRS, S_SMRS: begin
          state  <= S_GAP;
          follow <= followNext;
          gapCnt <= GAP_W'(GAP_CYCLES - 1);
          if (state == S_REF) refLeft <= refLeft - 1'b1;
        end
        S_GAP: begin
          if (gapCnt == '0) state <= follow;
          else              gapCnt <= gapCnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.doLatch = (state == S_SETTLE) && (settleCnt == '0);
    stb.doPre   = (state == S_PRE);
    stb.doRef   = (state == S_REF);
    stb.doMrs   = (state == S_MRS);
    stb.doSmrs  = (state == S_SMRS);
  end

  assign ready    = readyQ;
  assign cfgError = errQ;

  // ---- checking logic, kept apart from the control path ----
  logic anyCmd, seenCmd;
  logic [SINCE_W-1:0] sinceCmd;
  logic [REF_W:0]     refIssued;
  assign anyCmd = stb.doPre | stb.doRef | stb.doMrs | stb.doSmrs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenCmd   <= 1'b0;
      sinceCmd  <= '0;
      refIssued <= '0;
    end else begin
      if (anyCmd) begin
        seenCmd  <= 1'b1;
        sinceCmd <= '0;
      end else if (sinceCmd != SINCE_W'(GAP_CYCLES + 1)) begin
        sinceCmd <= sinceCmd + 1'b1;
      end
      if (stb.doRef) refIssued <= refIssued + 1'b1;
    end
  end

  p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.doPre, stb.doRef, stb.doMrs, stb.doSmrs}));

  p_spacing_r8: assert property (@(posedge clk) disable iff (!rstN)
    (anyCmd && seenCmd) |-> (sinceCmd == SINCE_W'(GAP_CYCLES)));

  p_ready_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  p_ref_total_r4: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (refIssued == (REF_W+1)'(REFRESH_COUNT)));

  p_fault_silent_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (!anyCmd && !ready));

endmodule

// File: rtl/sgramBootPath.sv
module sgramBootPath
  import sgramBootPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  stbT               stb,
  input  cfgT               cfgLive,
  output logic              cfgBad,
  output logic              modeFirst,
  output logic              specialEn,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic              dsf
);

  cfgT cfgQ;
  cmdT cmdQ;
  logic [ADDR_W-1:0] addrQ, modeWord, specWord, allBankWord;
  logic dsfQ;
  logic blReserved, fullInterleave, clBad, bothLoads;

  // legality of the live inputs, judged in the capture cycle
  always_comb begin
    blReserved     = (cfgLive.burstLen inside {3'b100, 3'b101, 3'b110});
    fullInterleave = (cfgLive.burstLen == 3'b111) && cfgLive.interleave;
    clBad          = !(cfgLive.casLat inside {3'd2, 3'd3});
    bothLoads      = cfgLive.specialEn && cfgLive.loadColor && cfgLive.loadMask;
    cfgBad         = blReserved | fullInterleave | clBad | bothLoads;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cfgQ <= '0;
    else if (stb.doLatch) cfgQ <= cfgLive;
  end

  assign modeFirst = cfgQ.modeFirst;
  assign specialEn = cfgQ.specialEn;

  always_comb begin
    modeWord                      = '0;
    modeWord[2:0]                 = cfgQ.burstLen;
    modeWord[BT_BIT]              = cfgQ.interleave;
    modeWord[CL_LSB+2:CL_LSB]     = cfgQ.casLat;
    modeWord[BIT_SINGLEWR]        = cfgQ.singleWrite;
    specWord                      = '0;
    specWord[BIT_LOADCOLOR]       = cfgQ.loadColor;
    specWord[BIT_LOADMASK]        = cfgQ.loadMask;
    allBankWord                   = '0;
    allBankWord[BIT_ALLBANK]      = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      dsfQ  <= 1'b0;
    end else begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      dsfQ  <= 1'b0;
      if (stb.doPre) begin
        cmdQ  <= CMD_PRE;
        addrQ <= allBankWord;
      end else if (stb.doRef) begin
        cmdQ  <= CMD_REF;
      end else if (stb.doMrs) begin
        cmdQ  <= CMD_MRS;
        addrQ <= modeWord;
      end else if (stb.doSmrs) begin
        cmdQ  <= CMD_MRS;
        addrQ <= specWord;
        dsfQ  <= 1'b1;
      end
    end
  end

  assign {csN, rasN, casN, weN} = cmdQ;
  assign addr = addrQ;
  assign dsf  = dsfQ;

  p_mode_reserved_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_MRS && !dsfQ) |->
      (!addrQ[BIT_ALLBANK] && addrQ[8:7] == 2'b00));

  p_special_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_MRS && dsfQ) |->
      !(addrQ[BIT_LOADCOLOR] && addrQ[BIT_LOADMASK]));

  p_dsf_only_mrs_r7: assert property (@(posedge clk) disable iff (!rstN)
    dsfQ |-> (cmdQ == CMD_MRS));

endmodule

// File: rtl/sgramBootSeq.sv
module sgramBootSeq
  import sgramBootPkg::*;
#(
  parameter int CLK_MHZ       = 125,
  parameter int SETTLE_US     = 200,
  parameter int REFRESH_COUNT = 2,
  parameter int GAP_CYCLES    = 2,
  parameter int ADDR_W        = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgBurstLen,
  input  logic              cfgInterleave,
  input  logic [2:0]        cfgCasLat,
  input  logic              cfgSingleWrite,
  input  logic              cfgModeFirst,
  input  logic              cfgSpecialEn,
  input  logic              cfgLoadColor,
  input  logic              cfgLoadMask,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic              dsf,
  output logic              ready,
  output logic              cfgError
);

  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

  stbT  stb;
  cfgT  cfgLive;
  logic cfgBad, modeFirst, specialEn;

  assign cfgLive = '{burstLen: cfgBurstLen, interleave: cfgInterleave,
                     casLat: cfgCasLat, singleWrite: cfgSingleWrite,
                     modeFirst: cfgModeFirst, specialEn: cfgSpecialEn,
                     loadColor: cfgLoadColor, loadMask: cfgLoadMask};

  assign cke = 1'b1;

  sgramBootCtrl #(
    .SETTLE_CYC   (SETTLE_CYC),
    .REFRESH_COUNT(REFRESH_COUNT),
    .GAP_CYCLES   (GAP_CYCLES)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgBad   (cfgBad),
    .modeFirst(modeFirst),
    .specialEn(specialEn),
    .stb      (stb),
    .ready    (ready),
    .cfgError (cfgError)
  );

  sgramBootPath #(
    .ADDR_W(ADDR_W)
  ) path (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cfgLive  (cfgLive),
    .cfgBad   (cfgBad),
    .modeFirst(modeFirst),
    .specialEn(specialEn),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .addr     (addr),
    .dsf      (dsf)
  );

endmodule

// File: tb/sgramBootSeq_test.sv
module sgramBootSeq_test;

  localparam int S   = 125;   // 125 MHz * 1 us
  localparam int R   = 3;
  localparam int G   = 2;
  localparam int RUN = 220;

  typedef struct packed {
    logic [2:0]  bl;
    logic        bt;
    logic [2:0]  cl;
    logic        sw, mf, sp, lc, lm, err;
    logic [10:0] word, sword;
  } vecT;

  localparam int NV = 14;
  localparam vecT VEC [NV] = '{
    '{3'b011, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'h023, 11'h000},
    '{3'b010, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'h23A, 11'h000},
    '{3'b111, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'h037, 11'h040},
    '{3'b000, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 11'h020, 11'h020},
    '{3'b001, 1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'h229, 11'h000},
    '{3'b100, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 11'h000, 11'h000},
    '{3'b110, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 11'h000, 11'h000},
    '{3'b111, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 11'h000, 11'h000},
    '{3'b011, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 11'h000, 11'h000},
    '{3'b011, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 11'h000, 11'h000},
    '{3'b011, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 11'h000, 11'h000},
    '{3'b011, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'h023, 11'h000},
    '{3'b101, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 11'h000, 11'h000},
    '{3'b111, 1'b0, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 11'h227, 11'h020}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic [2:0] cfgBurstLen, cfgCasLat;
  logic cfgInterleave, cfgSingleWrite, cfgModeFirst, cfgSpecialEn;
  logic cfgLoadColor, cfgLoadMask;
  logic cke, csN, rasN, casN, weN, dsf, ready, cfgError;
  logic [10:0] addr;

  sgramBootSeq #(
    .CLK_MHZ(125), .SETTLE_US(1), .REFRESH_COUNT(R), .GAP_CYCLES(G), .ADDR_W(11)
  ) uut (
    .clk(clk), .rstN(rstN),
    .cfgBurstLen(cfgBurstLen), .cfgInterleave(cfgInterleave),
    .cfgCasLat(cfgCasLat), .cfgSingleWrite(cfgSingleWrite),
    .cfgModeFirst(cfgModeFirst), .cfgSpecialEn(cfgSpecialEn),
    .cfgLoadColor(cfgLoadColor), .cfgLoadMask(cfgLoadMask),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .dsf(dsf), .ready(ready), .cfgError(cfgError)
  );

  int nRun = 0, nFail = 0;
  int cIdx [16];
  logic [3:0]  cCode [16];
  logic [10:0] cAddr [16];
  logic        cDsf  [16];
  int nCmd, readyIdx;
  bit readyLost, cmdAfterReady, ckeLow;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic applyCfg(input vecT v);
    cfgBurstLen = v.bl; cfgInterleave = v.bt; cfgCasLat = v.cl;
    cfgSingleWrite = v.sw; cfgModeFirst = v.mf; cfgSpecialEn = v.sp;
    cfgLoadColor = v.lc; cfgLoadMask = v.lm;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // sample index i is taken after the (i+1)-th rising edge since release
  task automatic capture(input int chgAt, input vecT alt);
    logic [3:0] code;
    nCmd = 0; readyIdx = -1; readyLost = 0; cmdAfterReady = 0; ckeLow = 0;
    for (int i = 0; i < RUN; i++) begin
      @(posedge clk);
      @(negedge clk);
      code = {csN, rasN, casN, weN};
      if (!cke) ckeLow = 1;
      if (code != 4'b0111) begin
        if (nCmd < 16) begin
          cIdx[nCmd] = i; cCode[nCmd] = code; cAddr[nCmd] = addr; cDsf[nCmd] = dsf;
        end
        nCmd++;
        if (readyIdx >= 0) cmdAfterReady = 1;
      end
      if (ready && readyIdx < 0) readyIdx = i;
      if (!ready && readyIdx >= 0) readyLost = 1;
      if (i == chgAt) applyCfg(alt);
    end
  endtask

  task automatic judge(input vecT v);
    logic [3:0]  eCode [16];
    logic [10:0] eAddr [16];
    logic        eDsf  [16];
    string       eReq  [16];
    int n = 0;
    int badGap = 0;
    if (v.err) begin
      check(nCmd == 0, "R10 no command on illegal cfg", nCmd, 0);
      check(cfgError == 1'b1, "R10 cfgError raised", cfgError, 1);
      check(readyIdx < 0, "R10 ready stays low", readyIdx, -1);
      return;
    end
    eCode[n] = 4'b0010; eAddr[n] = 11'h400; eDsf[n] = 0; eReq[n] = "R3 precharge-all"; n++;
    if (!v.mf) for (int k = 0; k < R; k++) begin
      eCode[n] = 4'b0001; eAddr[n] = 0; eDsf[n] = 0; eReq[n] = "R4/R5 refresh"; n++;
    end
    eCode[n] = 4'b0000; eAddr[n] = v.word; eDsf[n] = 0; eReq[n] = "R6 mode word"; n++;
    if (v.sp) begin
      eCode[n] = 4'b0000; eAddr[n] = v.sword; eDsf[n] = 1; eReq[n] = "R7 special word"; n++;
    end
    if (v.mf) for (int k = 0; k < R; k++) begin
      eCode[n] = 4'b0001; eAddr[n] = 0; eDsf[n] = 0; eReq[n] = "R4/R5 refresh"; n++;
    end
    check(nCmd == n, "R4 command count", nCmd, n);
    check(nCmd > 0 && cIdx[0] == S, "R2 settle length", nCmd > 0 ? cIdx[0] : -1, S);
    check(!ckeLow, "R2 cke high", ckeLow, 0);
    for (int k = 0; k < n && k < nCmd && k < 16; k++) begin
      check(cCode[k] == eCode[k] && cAddr[k] == eAddr[k] && cDsf[k] == eDsf[k],
            eReq[k], int'({cDsf[k], cCode[k], cAddr[k]}), int'({eDsf[k], eCode[k], eAddr[k]}));
      if (k > 0 && cIdx[k] - cIdx[k-1] != G + 1) badGap++;
    end
    check(badGap == 0, "R8 command spacing", badGap, 0);
    if (nCmd > 0 && nCmd <= 16)
      check(readyIdx == cIdx[nCmd-1] + G + 1, "R9 ready timing", readyIdx, cIdx[nCmd-1] + G + 1);
    check(!readyLost && !cmdAfterReady, "R9 ready sticky and quiet", int'({readyLost, cmdAfterReady}), 0);
    check(cfgError == 1'b0, "R10 no error on legal cfg", cfgError, 0);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    applyCfg(VEC[0]);
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check({csN, rasN, casN, weN} == 4'b0111 && addr == 0 && dsf == 0,
          "R1 pins idle in reset", int'({csN, rasN, casN, weN, addr}), 32'h3800);
    check(cke && !ready && !cfgError, "R1 flags in reset", int'({cke, ready, cfgError}), 4);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    check({csN, rasN, casN, weN} == 4'b0111 && !ready, "R1 first cycle idle",
          int'({csN, rasN, casN, weN}), 7);

    // table walk
    for (int v = 0; v < NV; v++) begin
      applyCfg(VEC[v]);
      doReset();
      capture(-1, VEC[v]);
      judge(VEC[v]);
    end

    // R11: change to illegal cfg in the precharge cycle, after capture
    applyCfg(VEC[0]);
    doReset();
    capture(S, VEC[5]);
    judge(VEC[0]);
    check(cfgError == 0, "R11 late change ignored", cfgError, 0);

    // R11: start illegal, switch to legal during settle
    applyCfg(VEC[6]);
    doReset();
    capture(10, VEC[1]);
    judge(VEC[1]);
    check(nCmd > 0, "R11 early change used", nCmd, 1 + R + 1);

    // R9/R1: reset clears a raised ready
    check(ready == 1'b1, "R9 ready high before reset", ready, 1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(ready == 1'b0 && cfgError == 1'b0, "R1 reset clears ready", ready, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R10: error stays after reset release with illegal cfg, cleared by reset
    applyCfg(VEC[10]);
    doReset();
    capture(-1, VEC[10]);
    judge(VEC[10]);
    applyCfg(VEC[0]);
    doReset();
    check(cfgError == 1'b0, "R1 reset clears cfgError", cfgError, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule